// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Path

This block sits between a peripheral with a 16-bit data bus and a byte-addressed memory port. A transfer request carries an address offset, a byte count, a direction (peripheral to memory or memory to peripheral) and a mode flag. The block builds the memory address by OR-ing the offset with a base register. It issues memory commands carrying an address and a byte count. It then moves the data one halfword at a time over valid/ready streams.

When the mode flag is high, the block uses the address, the length and the data exactly as given. When the flag is low, it clears bit 0 of the address and the length and swaps the two bytes of every halfword in both directions. In that mode, writes to memory are also split into chunks of at most a fixed size, 64 bytes by default. Each chunk gets its own command, and the address advances by the chunk size from one chunk to the next. A one-cycle done pulse marks the end of each request.

Top module: `hw_swap_dma`

## Requirements
- R1: The memory command address is the request offset bitwise-OR'd with the base register. The base register loads from `base_wdata` in a cycle where `base_we` is high, and it resets to zero.
- R2: With `req_pass`=1, the command address and length equal the formed address and the requested length, and each halfword passes through unchanged.
- R3: With `req_pass`=0, bit 0 of the formed address and bit 0 of the length are cleared before any command is issued.
- R4: With `req_pass`=0, each halfword is delivered with bits [15:8] and [7:0] exchanged. This applies to writes (`wr_in_data` to `mem_wdata`) and to reads (`mem_rdata` to `rd_out_data`).
- R5: With `req_pass`=0 and `req_to_mem`=1, the block issues consecutive commands of at most CHUNK bytes. Each command's address is the previous address plus the previous command's length. The remaining bytes shrink by that length, and the final command carries the remainder.
- R6: A read (`req_to_mem`=0), or a write with `req_pass`=1, is issued as a single command covering the whole aligned length.
- R7: Each command is followed by exactly ceil(length/2) halfword handshakes on the data stream for its direction.
- R8: A request whose aligned length is zero issues no memory command. `done` rises in the cycle after the request is accepted.
- R9: `done` is high for exactly one cycle. That cycle follows the clock edge at which the last halfword of the request was accepted.
- R10: Back-pressure stalls the transfer without losing or repeating a halfword. A command that is not yet accepted keeps `mem_cmd_valid` high, with its address and length unchanged.
- R11: After reset, `req_ready` is 1 and `done`, `mem_cmd_valid`, `mem_wvalid` and `rd_out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the base address register |
| base_wdata | input | AW | New base address value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_offset | input | AW | Address offset of the request |
| req_len | input | LW | Byte count of the request |
| req_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| req_pass | input | 1 | 1: no alignment or swap, 0: align and swap |
| wr_in_valid | input | 1 | Peripheral write halfword valid |
| wr_in_ready | output | 1 | Peripheral write halfword taken |
| wr_in_data | input | 16 | Peripheral write halfword |
| rd_out_valid | output | 1 | Read halfword for the peripheral valid |
| rd_out_ready | input | 1 | Peripheral accepts the read halfword |
| rd_out_data | output | 16 | Read halfword to the peripheral |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_addr | output | AW | Command byte address |
| mem_cmd_len | output | LW | Command byte count |
| mem_cmd_write | output | 1 | Command direction, 1 is write |
| mem_wvalid | output | 1 | Memory write halfword valid |
| mem_wready | input | 1 | Memory accepts the write halfword |
| mem_wdata | output | 16 | Memory write halfword |
| mem_rvalid | input | 1 | Memory read halfword valid |
| mem_rready | output | 1 | Block accepts the read halfword |
| mem_rdata | input | 16 | Memory read halfword |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
A wrong beat counter shows up at once as a missing or early `done`, or as an extra halfword handshake. It also makes the next chunk's command appear one cycle away from where it should be. A stale address or remainder register shows up in the very next command, as a wrong address or a wrong chunk length. A wrong mode latch shows up on the first data halfword as unswapped bytes, or as an odd address on the command. Because every one of these faults reaches a port within the request in progress, each test request is checked on every command and on every halfword.

// File: rtl/dma_swp_pkg.sv
package dma_swp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } xfer_st_e;

  // exchange the two bytes of one halfword
  function automatic logic [15:0] swap_halfword(input logic [15:0] d);
    return {d[7:0], d[15:8]};
  endfunction

  // clear bit 0 unless the request passes through untouched
  function automatic logic [63:0] align_even(input logic [63:0] v, input logic pass);
    return pass ? v : {v[63:1], 1'b0};
  endfunction

  // size of the next command: bounded only when splitting is active
  function automatic logic [63:0] chunk_of(input logic [63:0] rem, input logic split,
                                           input logic [63:0] limit);
    return (split && (rem > limit)) ? limit : rem;
  endfunction

  // halfword beats needed to carry a byte count
  function automatic logic [63:0] beats_of(input logic [63:0] len);
    return (len + 64'd1) >> 1;
  endfunction

endpackage

// File: rtl/dma_swp_lane.sv
module dma_swp_lane (
  input  logic        en,
  input  logic        swap,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [15:0] s_data,
  output logic        d_valid,
  input  logic        d_ready,
  output logic [15:0] d_data,
  output logic        fire
);
  import dma_swp_pkg::*;

  assign d_valid = en & s_valid;
  assign s_ready = en & d_ready;
  assign d_data  = swap ? swap_halfword(s_data) : s_data;
  assign fire    = en & s_valid & d_ready;

endmodule

// File: rtl/dma_swp_ctrl.sv
module dma_swp_ctrl #(
  parameter int AW    = 32,
  parameter int LW    = 12,
  parameter int CHUNK = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_to_mem,
  input  logic          req_pass,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [AW-1:0] cmd_addr,
  output logic [LW-1:0] cmd_len,
  output logic          cmd_write,
  output logic          data_phase,
  output logic          dir_write,
  output logic          pass_mode,
  input  logic          beat,
  output logic          last_beat,
  output logic          done
);
  import dma_swp_pkg::*;

  localparam logic [63:0] LIMIT = 64'(CHUNK);

  xfer_st_e      st_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q;
  logic [LW-1:0] chunk_q;
  logic [LW-1:0] hw_left_q;
  logic          wr_q;
  logic          pass_q;

  logic          accept;
  logic [AW-1:0] a_addr;
  logic [LW-1:0] a_len;
  logic [LW-1:0] rem_after;
  logic          split_q;

  always_comb begin
    accept    = req_valid && (st_q == ST_IDLE);
    a_addr    = AW'(align_even(64'(req_addr), req_pass));
    a_len     = LW'(align_even(64'(req_len), req_pass));
    rem_after = rem_q - chunk_q;
    split_q   = wr_q && !pass_q;
    last_beat = (st_q == ST_DATA) && beat && (hw_left_q == LW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      chunk_q   <= '0;
      hw_left_q <= '0;
      wr_q      <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q  <= a_addr;
          rem_q   <= a_len;
          wr_q    <= req_to_mem;
          pass_q  <= req_pass;
          chunk_q <= LW'(chunk_of(64'(a_len), req_to_mem && !req_pass, LIMIT));
          st_q    <= (a_len == '0) ? ST_FIN : ST_CMD;
        end
        ST_CMD: if (cmd_ready) begin
          hw_left_q <= LW'(beats_of(64'(chunk_q)));
          st_q      <= ST_DATA;
        end
        ST_DATA: if (beat) begin
          hw_left_q <= hw_left_q - LW'(1);
          if (last_beat) begin
            addr_q  <= addr_q + AW'(chunk_q);
            rem_q   <= rem_after;
            chunk_q <= LW'(chunk_of(64'(rem_after), split_q, LIMIT));
            st_q    <= (rem_after == '0) ? ST_FIN : ST_CMD;
          end
        end
        ST_FIN: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign cmd_valid  = (st_q == ST_CMD);
  assign cmd_addr   = addr_q;
  assign cmd_len    = chunk_q;
  assign cmd_write  = wr_q;
  assign data_phase = (st_q == ST_DATA);
  assign dir_write  = wr_q;
  assign pass_mode  = pass_q;
  assign done       = (st_q == ST_FIN);

endmodule

// File: rtl/hw_swap_dma.sv
module hw_swap_dma #(
  parameter int AW    = 32,
  parameter int LW    = 12,
  parameter int CHUNK = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_we,
  input  logic [AW-1:0] base_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_offset,
  input  logic [LW-1:0] req_len,
  input  logic          req_to_mem,
  input  logic          req_pass,
  input  logic          wr_in_valid,
  output logic          wr_in_ready,
  input  logic [15:0]   wr_in_data,
  output logic          rd_out_valid,
  input  logic          rd_out_ready,
  output logic [15:0]   rd_out_data,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic [AW-1:0] mem_cmd_addr,
  output logic [LW-1:0] mem_cmd_len,
  output logic          mem_cmd_write,
  output logic          mem_wvalid,
  input  logic          mem_wready,
  output logic [15:0]   mem_wdata,
  input  logic          mem_rvalid,
  output logic          mem_rready,
  input  logic [15:0]   mem_rdata,
  output logic          done
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] formed_addr;
  logic          data_phase;
  logic          dir_write;
  logic          pass_mode;
  logic          swap_active;
  logic          wr_fire;
  logic          rd_fire;
  logic          beat;
  logic          xfer_last;

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  assign formed_addr = req_offset | base_q;
  assign swap_active = !pass_mode;
  assign beat        = wr_fire | rd_fire;

  dma_swp_ctrl #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (formed_addr),
    .req_len    (req_len),
    .req_to_mem (req_to_mem),
    .req_pass   (req_pass),
    .cmd_valid  (mem_cmd_valid),
    .cmd_ready  (mem_cmd_ready),
    .cmd_addr   (mem_cmd_addr),
    .cmd_len    (mem_cmd_len),
    .cmd_write  (mem_cmd_write),
    .data_phase (data_phase),
    .dir_write  (dir_write),
    .pass_mode  (pass_mode),
    .beat       (beat),
    .last_beat  (xfer_last),
    .done       (done)
  );

  // peripheral -> memory
  dma_swp_lane u_wr_lane (
    .en      (data_phase & dir_write),
    .swap    (swap_active),
    .s_valid (wr_in_valid),
    .s_ready (wr_in_ready),
    .s_data  (wr_in_data),
    .d_valid (mem_wvalid),
    .d_ready (mem_wready),
    .d_data  (mem_wdata),
    .fire    (wr_fire)
  );

  // memory -> peripheral
  dma_swp_lane u_rd_lane (
    .en      (data_phase & !dir_write),
    .swap    (swap_active),
    .s_valid (mem_rvalid),
    .s_ready (mem_rready),
    .s_data  (mem_rdata),
    .d_valid (rd_out_valid),
    .d_ready (rd_out_ready),
    .d_data  (rd_out_data),
    .fire    (rd_fire)
  );

endmodule

// File: rtl/dma_swp_chk.sv
module dma_swp_chk #(
  parameter int AW    = 32,
  parameter int LW    = 12,
  parameter int CHUNK = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic          mem_cmd_valid,
  input logic          mem_cmd_ready,
  input logic [AW-1:0] mem_cmd_addr,
  input logic [LW-1:0] mem_cmd_len,
  input logic          mem_cmd_write,
  input logic          mem_wvalid,
  input logic          rd_out_valid,
  input logic          swap_active
);

  // R5
  chunk_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && mem_cmd_write && swap_active) |-> (64'(mem_cmd_len) <= 64'(CHUNK)));

  // R3
  even_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && swap_active) |-> (!mem_cmd_addr[0] && !mem_cmd_len[0]));

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_len)));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_cmd_valid && !req_ready));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_cmd_valid && !mem_wvalid && !rd_out_valid));

endmodule

bind hw_swap_dma dma_swp_chk #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .done          (done),
  .mem_cmd_valid (mem_cmd_valid),
  .mem_cmd_ready (mem_cmd_ready),
  .mem_cmd_addr  (mem_cmd_addr),
  .mem_cmd_len   (mem_cmd_len),
  .mem_cmd_write (mem_cmd_write),
  .mem_wvalid    (mem_wvalid),
  .rd_out_valid  (rd_out_valid),
  .swap_active   (swap_active)
);

// File: tb/test_hw_swap_dma.sv
module test_hw_swap_dma;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int CHUNK = 64;
  localparam int N = 9;
  localparam int WATCHDOG = 20000;

  // stimulus table: base, offset, length, to-memory, pass, stall
  localparam logic [31:0] T_BASE [N] = '{32'h1000_0000, 32'h1000_0000, 32'h2000_0100,
    32'h2000_0100, 32'h2000_0100, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] T_OFF  [N] = '{32'h41, 32'h41, 32'h23, 32'h10, 32'h03,
    32'h200, 32'h400, 32'h11, 32'h11};
  localparam int          T_LEN  [N] = '{10, 7, 150, 131, 5, 100, 128, 1, 0};
  localparam logic        T_WR   [N] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic        T_PASS [N] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic        T_STL  [N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [AW-1:0] base_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_offset = '0;
  logic [LW-1:0] req_len = '0;
  logic req_to_mem = 1'b0;
  logic req_pass = 1'b0;
  logic wr_in_valid = 1'b0;
  logic wr_in_ready;
  logic [15:0] wr_in_data = '0;
  logic rd_out_valid;
  logic rd_out_ready = 1'b0;
  logic [15:0] rd_out_data;
  logic mem_cmd_valid;
  logic mem_cmd_ready = 1'b0;
  logic [AW-1:0] mem_cmd_addr;
  logic [LW-1:0] mem_cmd_len;
  logic mem_cmd_write;
  logic mem_wvalid;
  logic mem_wready = 1'b0;
  logic [15:0] mem_wdata;
  logic mem_rvalid = 1'b0;
  logic mem_rready;
  logic [15:0] mem_rdata = '0;
  logic done;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hw_swap_dma #(.AW(AW), .LW(LW), .CHUNK(CHUNK)) i_hw_swap_dma (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int v, input int j);
    return 16'(v * 16'h1357 + j * 16'h0203 + 16'h00A5);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_xfer(input int v, input bit do_base, input logic [31:0] base,
                          input logic [31:0] off, input int len, input bit wr,
                          input bit pass, input bit stall);
    logic [31:0] a;
    int rem;
    int c;
    bit split;
    if (do_base) begin
      base_we = 1'b1; base_wdata = base;
      step();
      base_we = 1'b0;
    end
    a = off | base;
    if (!pass) a[0] = 1'b0;
    rem = pass ? len : (len & ~1);
    split = wr && !pass;
    chk(req_ready == 1'b1, "R11", "req_ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_offset = off; req_len = LW'(len);
    req_to_mem = wr; req_pass = pass;
    step();
    req_valid = 1'b0;
    if (rem == 0) begin
      // R8: no command, done in this cycle
      chk(mem_cmd_valid == 1'b0, "R8", "no command", 64'(mem_cmd_valid), 64'd0);
    end
    while (rem > 0) begin
      c = (split && rem > CHUNK) ? CHUNK : rem;
      chk(mem_cmd_valid == 1'b1, "R5", "command present", 64'(mem_cmd_valid), 64'd1);
      if (stall) begin
        mem_cmd_ready = 1'b0;
        step();
        // R10: command held while not accepted
        chk(mem_cmd_valid == 1'b1 && mem_cmd_addr == a, "R10", "held command",
            64'(mem_cmd_addr), 64'(a));
      end
      // R1 R2 R3: address; R5 R6: length
      chk(mem_cmd_addr == a, "R1", "command address", 64'(mem_cmd_addr), 64'(a));
      chk(mem_cmd_len == LW'(c), "R6", "command length", 64'(mem_cmd_len), 64'(c));
      chk(mem_cmd_write == wr, "R5", "command direction", 64'(mem_cmd_write), 64'(wr));
      mem_cmd_ready = 1'b1;
      step();
      mem_cmd_ready = 1'b0;
      for (int j = 0; j < (c + 1) / 2; ) begin
        logic [15:0] h;
        logic [15:0] e;
        h = pat(v, j);
        e = pass ? h : {h[7:0], h[15:8]};
        if (wr) begin
          wr_in_valid = !(stall && (cyc % 3 == 0));
          mem_wready  = !(stall && (cyc % 2 == 1));
          wr_in_data  = h;
          #1;
          if (wr_in_valid && mem_wready) begin
            chk(mem_wvalid && wr_in_ready, "R10", "write handshake", 64'(mem_wvalid), 64'd1);
            chk(mem_wdata == e, pass ? "R2" : "R4", "write halfword", 64'(mem_wdata), 64'(e));
            j++;
          end
        end else begin
          mem_rvalid   = !(stall && (cyc % 3 == 0));
          rd_out_ready = !(stall && (cyc % 2 == 1));
          mem_rdata    = h;
          #1;
          if (mem_rvalid && rd_out_ready) begin
            chk(rd_out_valid && mem_rready, "R10", "read handshake", 64'(rd_out_valid), 64'd1);
            chk(rd_out_data == e, pass ? "R2" : "R4", "read halfword", 64'(rd_out_data), 64'(e));
            j++;
          end
        end
        step();
        wr_in_valid = 1'b0; mem_wready = 1'b0;
        mem_rvalid = 1'b0; rd_out_ready = 1'b0;
      end
      a = a + 32'(c);
      rem = rem - c;
    end
    // R7 R9: done right after the last halfword, for one cycle
    chk(done == 1'b1, "R9", "done after last halfword", 64'(done), 64'd1);
    chk(mem_cmd_valid == 1'b0, "R7", "no extra command", 64'(mem_cmd_valid), 64'd0);
    step();
    chk(done == 1'b0, "R9", "done single cycle", 64'(done), 64'd0);
    chk(req_ready == 1'b1, "R9", "idle after done", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <%0d cycles", WATCHDOG, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(req_ready == 1'b1, "R11", "req_ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R11", "done", 64'(done), 64'd0);
    chk(mem_cmd_valid == 1'b0, "R11", "mem_cmd_valid", 64'(mem_cmd_valid), 64'd0);
    chk(mem_wvalid == 1'b0 && rd_out_valid == 1'b0, "R11", "data valids",
        64'({mem_wvalid, rd_out_valid}), 64'd0);
    // R11 R1: base register resets to zero
    run_xfer(99, 1'b0, 32'h0, 32'h55, 2, 1'b0, 1'b1, 1'b0);
    // table walk: R1..R10
    for (int i = 0; i < N; i++)
      run_xfer(i, 1'b1, T_BASE[i], T_OFF[i], T_LEN[i], T_WR[i], T_PASS[i], T_STL[i]);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule